// File: doc/BRIEF.md
# Register-Block and Byte-String Transfer Sequencer

This block drives the data movement for two kinds of bulk transfers between memory and the general register file. In a grouped-word transfer, one memory word moves per beat, from a starting register up to the last register. In a byte-string transfer, one memory byte moves per beat for a given byte count. A single-cycle `start` pulse in the idle state latches the operation kind, the direction, the page byte-order attribute, the first register number, the first address and the byte count. The sequencer then issues one memory request per clock, together with the matching register-file read or write strobe, and raises `done` for one cycle once the last beat has finished.

The memory and the register file are outside the block. Both answer combinationally within the beat: `mem_rdata` reflects `mem_addr` in the same cycle, and `rf_rd_data` reflects `rf_rd_idx` in the same cycle. Lane `i` of a memory data bus (bits `8i+7:8i`) carries the byte at address `mem_addr + i`. A byte-sized beat uses lane 0 only. `mem_size` is 1 for a word beat and 0 for a byte beat.

Grouped-word transfers follow the page byte order. Byte-string transfers ignore it, so that two strings loaded into registers compare in lexical order.

Top module: `regxfer_seq`

## Requirements
- R1: While reset is asserted and after it is released, `done`, `mem_req`, `mem_we`, `rf_we` and `rf_re` are low until a start is accepted.
- R2: A grouped-word transfer (`op_string`=0) makes exactly 32 − `start_reg` word beats (`mem_size`=1), one per clock, over registers `start_reg` up to 31 in order, at addresses `start_addr`, `start_addr`+4, and so on. `byte_count` is ignored.
- R3: On a grouped-word load with `page_big_end`=1, the byte at the lowest address of the word becomes bits 31:24 of the register. With `page_big_end`=0 it becomes bits 7:0, and the remaining bytes follow in the same order.
- R4: A grouped-word store writes each register to memory with the same byte arrangement as R3, with `mem_we`=1 and `rf_re`=1 on every beat.
- R5: A byte-string transfer (`op_string`=1) makes exactly `byte_count` byte beats (`mem_size`=0), using lane 0. The byte at `start_addr` pairs with bits 31:24 of `start_reg` for either value of `page_big_end`.
- R6: String byte k pairs with address `start_addr`+k. Within a register the bytes run from bits 31:24 down to bits 7:0, and the next byte then continues at bits 31:24 of the next register.
- R7: On a string load whose count is not a multiple of 4, the unused low-order bytes of the last register are written as zero.
- R8: During a string transfer, the register number after 31 is 0.
- R9: A string transfer with `byte_count`=0 makes no memory request and no register access, and asserts `done` in the cycle after the start.
- R10: `done` is high for exactly one cycle, in the cycle after the last beat. A `start` seen while a transfer is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse, accepted only when idle |
| op_string | input | 1 | 1 = byte-string transfer, 0 = grouped-word transfer |
| op_store | input | 1 | 1 = register to memory, 0 = memory to register |
| page_big_end | input | 1 | Page byte order, 1 = big endian |
| start_reg | input | 5 | First register number |
| start_addr | input | 32 | First byte address |
| byte_count | input | 7 | String length in bytes |
| done | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory beat valid |
| mem_we | output | 1 | Memory write (store) |
| mem_size | output | 1 | 1 = word beat, 0 = byte beat |
| mem_addr | output | 32 | Beat address |
| mem_wdata | output | 32 | Store data, lane i = byte at mem_addr+i |
| mem_rdata | input | 32 | Load data, same lane convention |
| rf_re | output | 1 | Register read strobe |
| rf_rd_idx | output | 5 | Register read index |
| rf_rd_data | input | 32 | Register read data |
| rf_we | output | 1 | Register write strobe |
| rf_wr_idx | output | 5 | Register write index |
| rf_wdata | output | 32 | Register write data |

## Verification
On every cycle, the bound assertions check the following:
- `done` lasts a single cycle and is followed by an idle cycle.
- Consecutive beats step the address by 4 for word beats and by 1 for byte beats.
- Word beats advance the register by one and never wrap.
- String beats keep the register or move to the next one.
- Stored string bytes occupy lane 0 only.
- Register and memory strobes match the direction.

Only the bench scenarios can show the data values themselves. These are the byte arrangement under each page order, the string register-byte mapping across the 31-to-0 wrap, the zero fill of a partial register, the zero-length case, and the rejection of a start issued mid-transfer. The bench shows them by comparing the full memory and register contents with a reference computed independently.

// File: rtl/regxfer_pkg.sv
package regxfer_pkg;

   typedef enum logic [1:0] {
      XS_IDLE = 2'd0,
      XS_MOVE = 2'd1,
      XS_FIN  = 2'd2
   } xfer_state_e;

   typedef struct packed {
      logic is_str;
      logic is_store;
      logic big_end;
   } xfer_mode_t;

endpackage

// File: rtl/regxfer_lane_swap.sv
module regxfer_lane_swap #(
   parameter int BYTES = 4
) (
   input  logic                 swap,
   input  logic [8*BYTES-1:0]   din,
   output logic [8*BYTES-1:0]   dout
);
   for (genvar i = 0; i < BYTES; i++) begin : g_lane
      localparam int MIRROR = BYTES - 1 - i;
      assign dout[8*i +: 8] = swap ? din[8*MIRROR +: 8] : din[8*i +: 8];
   end
endmodule

// File: rtl/regxfer_str_pack.sv
module regxfer_str_pack #(
   parameter int BYTES = 4,
   localparam int POS_W = $clog2(BYTES),
   localparam int DATA_W = 8 * BYTES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              beat,
   input  logic              flush,
   input  logic [POS_W-1:0]  pos,
   input  logic [7:0]        in_byte,
   output logic [DATA_W-1:0] merged
);
   logic [DATA_W-1:0] acc_q;

   // byte at position p (0 = most significant) lands in lane BYTES-1-p
   for (genvar i = 0; i < BYTES; i++) begin : g_place
      localparam logic [POS_W-1:0] HIT = POS_W'(BYTES - 1 - i);
      assign merged[8*i +: 8] = (pos == HIT) ? in_byte : acc_q[8*i +: 8];
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
         acc_q <= '0;
      end else if (beat) begin
         acc_q <= flush ? '0 : merged;
      end
   end
endmodule

// File: rtl/regxfer_seq_ctrl.sv
module regxfer_seq_ctrl
   import regxfer_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int IDX_W  = 5,
   parameter int CNT_W  = 7,
   parameter int BYTES  = 4,
   localparam int POS_W  = $clog2(BYTES),
   localparam int LEFT_W = (CNT_W > IDX_W + 1) ? CNT_W : IDX_W + 1,
   localparam int NUM_REGS = 1 << IDX_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  xfer_mode_t        mode_in,
   input  logic [IDX_W-1:0]  sreg,
   input  logic [ADDR_W-1:0] saddr,
   input  logic [CNT_W-1:0]  count,
   output logic              active,
   output logic              fin,
   output logic              accept,
   output xfer_mode_t        mode,
   output logic [ADDR_W-1:0] cur_addr,
   output logic [IDX_W-1:0]  cur_reg,
   output logic [POS_W-1:0]  cur_pos,
   output logic              last_beat
);
   xfer_state_e       state_q, state_d;
   logic [LEFT_W-1:0] left_q;
   logic [LEFT_W-1:0] left_init;
   logic              reg_adv;

   assign active    = (state_q == XS_MOVE);
   assign fin       = (state_q == XS_FIN);
   assign accept    = (state_q == XS_IDLE) && start;
   assign last_beat = active && (left_q == LEFT_W'(1));
   assign reg_adv   = !mode.is_str || (cur_pos == POS_W'(BYTES - 1));
   assign left_init = mode_in.is_str ? LEFT_W'(count)
                                     : LEFT_W'(NUM_REGS) - LEFT_W'(sreg);

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         XS_IDLE: if (start) state_d = (left_init == '0) ? XS_FIN : XS_MOVE;
         XS_MOVE: if (last_beat) state_d = XS_FIN;
         XS_FIN:  state_d = XS_IDLE;
         default: state_d = XS_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= XS_IDLE;
         mode     <= '0;
         cur_addr <= '0;
         cur_reg  <= '0;
         cur_pos  <= '0;
         left_q   <= '0;
      end else begin
         state_q <= state_d;
         if (accept) begin
            mode     <= mode_in;
            cur_addr <= saddr;
            cur_reg  <= sreg;
            cur_pos  <= '0;
            left_q   <= left_init;
         end else if (active) begin
            cur_addr <= cur_addr + (mode.is_str ? ADDR_W'(1) : ADDR_W'(BYTES));
            cur_pos  <= mode.is_str ? cur_pos + POS_W'(1) : '0;
            left_q   <= left_q - LEFT_W'(1);
            if (reg_adv) cur_reg <= cur_reg + IDX_W'(1);
         end
      end
   end
endmodule

// File: rtl/regxfer_seq.sv
module regxfer_seq
   import regxfer_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int IDX_W  = 5,
   parameter int CNT_W  = 7,
   parameter int BYTES  = 4,
   localparam int DATA_W = 8 * BYTES,
   localparam int POS_W  = $clog2(BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              op_string,
   input  logic              op_store,
   input  logic              page_big_end,
   input  logic [IDX_W-1:0]  start_reg,
   input  logic [ADDR_W-1:0] start_addr,
   input  logic [CNT_W-1:0]  byte_count,
   output logic              done,
   output logic              mem_req,
   output logic              mem_we,
   output logic              mem_size,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              rf_re,
   output logic [IDX_W-1:0]  rf_rd_idx,
   input  logic [DATA_W-1:0] rf_rd_data,
   output logic              rf_we,
   output logic [IDX_W-1:0]  rf_wr_idx,
   output logic [DATA_W-1:0] rf_wdata
);
   if (BYTES < 2 || (BYTES & (BYTES - 1)) != 0) begin : g_bad_bytes
      $error("regxfer_seq: BYTES must be a power of two, at least 2");
   end
   if (IDX_W < 1 || CNT_W < 1 || ADDR_W < POS_W + 1) begin : g_bad_width
      $error("regxfer_seq: index, count or address width too small");
   end

   xfer_mode_t        mode_in, mode;
   logic              active, fin, accept, last_beat;
   logic [ADDR_W-1:0] cur_addr;
   logic [IDX_W-1:0]  cur_reg;
   logic [POS_W-1:0]  cur_pos;
   logic [DATA_W-1:0] word_load, word_store, str_word;
   logic [7:0]        str_pick;
   logic              str_flush;

   assign mode_in = '{is_str: op_string, is_store: op_store, big_end: page_big_end};

   regxfer_seq_ctrl #(
      .ADDR_W(ADDR_W), .IDX_W(IDX_W), .CNT_W(CNT_W), .BYTES(BYTES)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start), .mode_in(mode_in),
      .sreg(start_reg), .saddr(start_addr), .count(byte_count),
      .active(active), .fin(fin), .accept(accept), .mode(mode),
      .cur_addr(cur_addr), .cur_reg(cur_reg), .cur_pos(cur_pos),
      .last_beat(last_beat)
   );

   // word beats: page byte order applies, the same swap serves both directions
   regxfer_lane_swap #(.BYTES(BYTES)) u_swap_ld (
      .swap(mode.big_end), .din(mem_rdata), .dout(word_load)
   );
   regxfer_lane_swap #(.BYTES(BYTES)) u_swap_st (
      .swap(mode.big_end), .din(rf_rd_data), .dout(word_store)
   );

   // string beats: byte order ignored, most significant byte first
   always_comb begin
      str_pick = '0;
      for (int i = 0; i < BYTES; i++) begin
         if (cur_pos == POS_W'(BYTES - 1 - i)) str_pick = rf_rd_data[8*i +: 8];
      end
   end

   assign str_flush = (cur_pos == POS_W'(BYTES - 1)) || last_beat;

   regxfer_str_pack #(.BYTES(BYTES)) u_pack (
      .clk(clk), .rst_n(rst_n), .clear(accept),
      .beat(active && mode.is_str && !mode.is_store),
      .flush(str_flush), .pos(cur_pos), .in_byte(mem_rdata[7:0]),
      .merged(str_word)
   );

   assign done      = fin;
   assign mem_req   = active;
   assign mem_we    = active && mode.is_store;
   assign mem_size  = active && !mode.is_str;
   assign mem_addr  = cur_addr;
   assign mem_wdata = mode.is_str ? {{(DATA_W - 8){1'b0}}, str_pick} : word_store;
   assign rf_re     = active && mode.is_store;
   assign rf_rd_idx = cur_reg;
   assign rf_we     = active && !mode.is_store && (!mode.is_str || str_flush);
   assign rf_wr_idx = cur_reg;
   assign rf_wdata  = mode.is_str ? str_word : word_load;
endmodule

// File: rtl/regxfer_seq_chk.sv
module regxfer_seq_chk #(
   parameter int ADDR_W = 32,
   parameter int IDX_W  = 5,
   parameter int CNT_W  = 7,
   parameter int BYTES  = 4,
   localparam int DATA_W = 8 * BYTES
) (
   input logic              clk,
   input logic              rst_n,
   input logic              done,
   input logic              mem_req,
   input logic              mem_we,
   input logic              mem_size,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [DATA_W-1:0] mem_wdata,
   input logic              rf_re,
   input logic [IDX_W-1:0]  rf_rd_idx,
   input logic              rf_we
);
   assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_idle_after_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !mem_req);

   assert_no_beat_with_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> !done);

   assert_addr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && $past(mem_req)) |->
         (mem_addr == $past(mem_addr) + (mem_size ? ADDR_W'(BYTES) : ADDR_W'(1))));

   assert_word_reg_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_size && $past(mem_req)) |->
         (rf_rd_idx == $past(rf_rd_idx) + IDX_W'(1)) && (rf_rd_idx != '0));

   assert_string_reg_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_size && $past(mem_req)) |->
         (rf_rd_idx == $past(rf_rd_idx)) || (rf_rd_idx == $past(rf_rd_idx) + IDX_W'(1)));

   assert_byte_lane_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we && !mem_size) |-> (mem_wdata[DATA_W-1:8] == '0));

   assert_store_strobes_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rf_re |-> (mem_req && mem_we && !rf_we));

   assert_load_strobes_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rf_we |-> (mem_req && !mem_we && !rf_re));

   assert_quiet_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_req |-> (!mem_we && !rf_we && !rf_re));
endmodule

bind regxfer_seq regxfer_seq_chk #(
   .ADDR_W(ADDR_W), .IDX_W(IDX_W), .CNT_W(CNT_W), .BYTES(BYTES)
) u_chk (.*);

// File: tb/regxfer_seq_test.sv
`timescale 1ns/1ps
module regxfer_seq_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        op_string = 1'b0, op_store = 1'b0, page_big_end = 1'b0;
   logic [4:0]  start_reg = '0;
   logic [31:0] start_addr = '0;
   logic [6:0]  byte_count = '0;
   logic        done, mem_req, mem_we, mem_size, rf_re, rf_we;
   logic [31:0] mem_addr, mem_wdata, mem_rdata, rf_rd_data, rf_wdata;
   logic [4:0]  rf_rd_idx, rf_wr_idx;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 0;

   always #4 clk = ~clk;

   regxfer_seq uut (
      .clk(clk), .rst_n(rst_n), .start(start), .op_string(op_string),
      .op_store(op_store), .page_big_end(page_big_end), .start_reg(start_reg),
      .start_addr(start_addr), .byte_count(byte_count), .done(done),
      .mem_req(mem_req), .mem_we(mem_we), .mem_size(mem_size),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .rf_re(rf_re), .rf_rd_idx(rf_rd_idx), .rf_rd_data(rf_rd_data),
      .rf_we(rf_we), .rf_wr_idx(rf_wr_idx), .rf_wdata(rf_wdata)
   );

   // external memory (256 bytes) and register file models
   logic [7:0]  mem [256];
   logic [31:0] rf  [32];
   logic [7:0]  exp_mem [256];
   logic [31:0] exp_rf  [32];
   logic        init_req = 1'b0;
   int          seed = 0;
   int          beats = 0;
   int          rf_hits = 0;

   function automatic logic [7:0] pat_mem(int i, int s);
      return 8'(i * 37 + s * 11 + 5);
   endfunction
   function automatic logic [31:0] pat_rf(int r, int s);
      return 32'hA5C3_0F17 ^ (32'(r) * 32'h0102_0409) ^ (32'(s) << 20);
   endfunction

   always_comb begin
      for (int i = 0; i < 4; i++) mem_rdata[8*i +: 8] = mem[8'(mem_addr + 32'(i))];
      rf_rd_data = rf[rf_rd_idx];
   end

   always @(posedge clk) begin
      if (init_req) begin
         for (int i = 0; i < 256; i++) mem[i] <= pat_mem(i, seed);
         for (int r = 0; r < 32; r++) rf[r] <= pat_rf(r, seed);
         beats   <= 0;
         rf_hits <= 0;
      end else begin
         if (mem_req) beats <= beats + 1;
         if (rf_we || rf_re) rf_hits <= rf_hits + 1;
         if (mem_req && mem_we) begin
            if (mem_size)
               for (int j = 0; j < 4; j++) mem[8'(mem_addr + 32'(j))] <= mem_wdata[8*j +: 8];
            else
               mem[mem_addr[7:0]] <= mem_wdata[7:0];
         end
         if (rf_we) rf[rf_wr_idx] <= rf_wdata;
      end
   end

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint expv);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
      end
   endtask

   // independent reference of the requirements
   task automatic build_expected(input bit is_str, input bit st, input bit be,
                                 input int sr, input int a, input int n);
      for (int i = 0; i < 256; i++) exp_mem[i] = pat_mem(i, seed);
      for (int r = 0; r < 32; r++) exp_rf[r] = pat_rf(r, seed);
      if (!is_str) begin
         for (int r = sr; r < 32; r++) begin
            int wa = a + 4 * (r - sr);
            if (!st) begin
               logic [7:0] b0, b1, b2, b3;
               b0 = exp_mem[8'(wa)];     b1 = exp_mem[8'(wa + 1)];
               b2 = exp_mem[8'(wa + 2)]; b3 = exp_mem[8'(wa + 3)];
               exp_rf[r] = be ? {b0, b1, b2, b3} : {b3, b2, b1, b0};
            end else begin
               for (int j = 0; j < 4; j++)
                  exp_mem[8'(wa + j)] = be ? exp_rf[r][31 - 8*j -: 8] : exp_rf[r][8*j +: 8];
            end
         end
      end else begin
         for (int k = 0; k < n; k++) begin
            int r = (sr + k / 4) % 32;
            int p = k % 4;
            if (!st) begin
               if (p == 0) exp_rf[r] = '0;
               exp_rf[r][31 - 8*p -: 8] = exp_mem[8'(a + k)];
            end else begin
               exp_mem[8'(a + k)] = exp_rf[r][31 - 8*p -: 8];
            end
         end
      end
   endtask

   // vector: {op_string, op_store, page_big_end, start_reg[4:0], start_addr[7:0], byte_count[6:0]}
   localparam logic [22:0] VEC [9] = '{
      {1'b0, 1'b0, 1'b1, 5'd28, 8'h10, 7'd0},
      {1'b0, 1'b0, 1'b0, 5'd29, 8'h21, 7'd0},
      {1'b0, 1'b1, 1'b1, 5'd27, 8'h40, 7'd0},
      {1'b0, 1'b1, 1'b0, 5'd0,  8'h00, 7'd0},
      {1'b1, 1'b0, 1'b1, 5'd5,  8'h33, 7'd10},
      {1'b1, 1'b0, 1'b0, 5'd30, 8'h50, 7'd13},
      {1'b1, 1'b1, 1'b0, 5'd31, 8'h07, 7'd9},
      {1'b1, 1'b1, 1'b1, 5'd2,  8'h80, 7'd127},
      {1'b1, 1'b0, 1'b0, 5'd0,  8'hC4, 7'd4}
   };

   task automatic run_op(input logic [22:0] v, input bit poke, input string tag);
      bit is_str, st, be;
      int sr, a, n, expb, lat, bad;
      {is_str, st, be} = v[22:20];
      sr = int'(v[19:15]); a = int'(v[14:7]); n = int'(v[6:0]);
      seed++;
      @(negedge clk); init_req = 1'b1;
      @(negedge clk); init_req = 1'b0;
      build_expected(is_str, st, be, sr, a, n);
      expb = is_str ? n : 32 - sr;
      op_string = is_str; op_store = st; page_big_end = be;
      start_reg = 5'(sr); start_addr = 32'(a); byte_count = 7'(n);
      start = 1'b1;
      @(negedge clk); start = 1'b0;
      lat = 1;
      while (!done && lat < 400) begin
         if (poke && lat == 2) begin
            start = 1'b1; op_store = ~st; start_reg = 5'd1;
            start_addr = 32'h0; byte_count = 7'd20;
         end else begin
            start = 1'b0;
         end
         @(negedge clk); lat++;
      end
      start = 1'b0;
      check(done == 1'b1, tag, "done within timeout", done, 1);
      check(lat == expb + 1, "R10", {tag, " done latency"}, lat, expb + 1);
      check(beats == expb, tag, "beat count", beats, expb);
      @(negedge clk);
      check(done == 1'b0, "R10", {tag, " done width"}, done, 0);
      repeat (3) @(negedge clk);
      check(beats == expb, "R10", {tag, " no extra beats"}, beats, expb);
      bad = 0;
      for (int r = 0; r < 32; r++) if (rf[r] !== exp_rf[r]) begin
         if (bad == 0) check(0, tag, $sformatf("reg %0d", r), rf[r], exp_rf[r]);
         bad++;
      end
      if (bad == 0) check(1, tag, "registers", 0, 0);
      bad = 0;
      for (int i = 0; i < 256; i++) if (mem[i] !== exp_mem[i]) begin
         if (bad == 0) check(0, tag, $sformatf("mem byte %0h", i), mem[i], exp_mem[i]);
         bad++;
      end
      if (bad == 0) check(1, tag, "memory", 0, 0);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: quiet during and right after reset
      check(!done && !mem_req && !mem_we && !rf_we && !rf_re, "R1", "in reset",
            {done, mem_req, mem_we, rf_we, rf_re}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(!done && !mem_req && !rf_we && !rf_re, "R1", "after reset",
            {done, mem_req, rf_we, rf_re}, 0);

      // table: R2 R3 word loads, R4 word stores, R5 R6 R7 R8 string cases
      for (int t = 0; t < 9; t++) begin
         string tg;
         tg = (t < 2) ? "R3" : (t < 4) ? "R4" : (t == 4) ? "R7" :
              (t == 5) ? "R8" : (t == 6) ? "R8" : (t == 7) ? "R6" : "R5";
         run_op(VEC[t], 1'b0, tg);
      end

      // R2: grouped transfer from register 31 is a single word
      run_op({1'b0, 1'b0, 1'b1, 5'd31, 8'hF0, 7'd55}, 1'b0, "R2");
      // R5: string byte order independent of page attribute
      run_op({1'b1, 1'b1, 1'b0, 5'd9, 8'h60, 7'd6}, 1'b0, "R5");
      // R10: start pulse in the middle of a transfer is ignored
      run_op({1'b1, 1'b0, 1'b1, 5'd12, 8'h20, 7'd30}, 1'b1, "R10");
      run_op({1'b0, 1'b1, 1'b1, 5'd20, 8'h90, 7'd0}, 1'b1, "R10");
      // R9: zero-length string
      run_op({1'b1, 1'b0, 1'b1, 5'd4, 8'h10, 7'd0}, 1'b0, "R9");
      check(rf_hits == 0, "R9", "register activity", rf_hits, 0);

      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end
endmodule